// File: doc/BRIEF.md
# Key-Gated Register Front End with Interrupt Unit

This block is the register-bus face of a fuse controller. Every register write passes through a lock gate. After reset the gate is closed. It opens only when one exact 32-bit key word is written to the lock register. While the gate is closed, writes to any other register are dropped. Each dropped write raises a bus-error status flag, so software can see that the write was refused.

The same block holds a small interrupt unit with one level output. Completion and error pulses from the program and read engines set sticky status bits. Software clears those bits with write-one-to-clear. The mask can only be changed through two side registers: one sets mask bits and one clears them. Four timing words are also kept here as plain storage for the engines. All accesses are single 32-bit words, selected by a word address.

Word map (word address : register): 0 lock, 1 status, 2 mask (read-only), 3 mask-set, 4 mask-clear, 5 to 8 timing words 0 to 3.

Top module: `fgate_top`

## Requirements
- R1: After reset the lock register reads 1. The mask reads 0x8000001F and the status reads 0. `irq_o` is low. Timing words 0 to 3 read 0x1B, 0xFF, 0x0B and 0x07.
- R2: A write of exactly 0x0000DF0D to word 0 makes the lock read 0 (open) from the next cycle. A write of any other 32-bit value makes it read 1 (closed).
- R3: While the lock reads 1, a write to any word other than 0 changes no register. It also sets status bit 31 on the next cycle.
- R4: A write to word 0 is always accepted, whether the lock is open or closed, so an open gate can be closed again.
- R5: Pulses on `evt_i` bits 0 to 4 set status bits 0 to 4: program done, program error, read done, read error and cache error. Status bits 5 to 30 always read 0.
- R6: Writing word 1 clears each status bit in 0x8000001F where the data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R7: When an event pulse and a clear of the same status bit happen in the same cycle, the bit stays set.
- R8: A write to word 3 ORs the data into the mask, limited to 0x8000001F. A write to word 4 clears the written bits from the mask. Words 3 and 4 read 0. A write to word 2 has no effect.
- R9: `irq_o` is high exactly when status AND mask is nonzero. It follows each status, mask or event change one cycle after the triggering write or pulse.
- R10: Timing words store the low 8 bits of an accepted write and read them back zero-extended. They have no effect on the interrupt or on the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one word per cycle |
| rd_i | input | 1 | Read strobe; `rdata_o` is 0 when this is low |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| evt_i | input | 5 | Engine event pulses (status bits 0 to 4) |
| irq_o | output | 1 | Level interrupt |

## Verification
Assertions check on every cycle that:
- the key opens the gate and any other value closes it;
- a refused write raises the error flag and leaves the timing words stable;
- an event always wins over a clear of the same bit;
- mask-set and mask-clear writes move exactly the written mask bits.

Other behaviour is shown only by the bench scenarios. These cover the reset values and the read-as-zero words. They also cover the one-cycle interrupt response to clears and mask changes, keys that differ only in the upper half, re-locking from the open state, and writes to the read-only mask being ignored.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
  localparam int          DW        = 32;
  localparam int          NUM_EVT   = 5;
  localparam int          ERR_BIT   = 31;
  localparam logic [31:0] LOCK_KEY  = 32'h0000_DF0D;
  localparam logic [31:0] STAT_IMPL = 32'h8000_001F;

  localparam int W_LOCK = 0;
  localparam int W_STAT = 1;
  localparam int W_MASK = 2;
  localparam int W_MEN  = 3;
  localparam int W_MDIS = 4;
  localparam int W_TIM0 = 5;

  function automatic logic [7:0] tim_rst(int idx);
    case (idx)
      0:       return 8'h1B;
      1:       return 8'hFF;
      2:       return 8'h0B;
      default: return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/fgate_lock.sv
module fgate_lock
  import fgate_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          lock_sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o,
  output logic          wr_pass_o,
  output logic          viol_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 locked_q <= 1'b1;
    else if (wr_i && lock_sel_i) locked_q <= (wdata_i != LOCK_KEY);
  end

  assign locked_o  = locked_q;
  assign wr_pass_o = wr_i && !lock_sel_i && !locked_q;
  assign viol_o    = wr_i && !lock_sel_i && locked_q;

  // R2
  key_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && lock_sel_i && wdata_i == LOCK_KEY) |=> !locked_o);
  // R2
  key_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && lock_sel_i && wdata_i != LOCK_KEY) |=> locked_o);
endmodule

// File: rtl/fgate_irq.sv
module fgate_irq
  import fgate_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_stat_i,
  input  logic               wr_en_i,
  input  logic               wr_dis_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               viol_i,
  output logic [DW-1:0]      stat_o,
  output logic [DW-1:0]      mask_o,
  output logic               irq_o
);
  logic [DW-1:0] stat_q, stat_d, mask_q, mask_d, set_v, clr_v;

  always_comb begin
    set_v                = '0;
    set_v[NUM_EVT-1:0]   = evt_i;
    set_v[ERR_BIT]       = viol_i;
    clr_v                = wr_stat_i ? wdata_i : '0;
    // set after clear: event wins
    stat_d = ((stat_q & ~clr_v) | set_v) & STAT_IMPL;
    mask_d = mask_q;
    if (wr_en_i)  mask_d = mask_d | (wdata_i & STAT_IMPL);
    if (wr_dis_i) mask_d = mask_d & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= STAT_IMPL;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);

  // R7
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_o[NUM_EVT-1:0] & $past(evt_i)) == $past(evt_i)));
  // R3
  viol_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> stat_o[ERR_BIT]);
  // R8
  mask_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dis_i && !wr_en_i) |=> ((mask_o & $past(wdata_i)) == '0));
  // R8
  mask_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_dis_i) |=>
      ((mask_o & $past(wdata_i) & STAT_IMPL) == ($past(wdata_i) & STAT_IMPL)));
endmodule

// File: rtl/fgate_tim.sv
module fgate_tim #(
  parameter int TIM_N = 4,
  parameter int TIM_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [TIM_N-1:0]            we_i,
  input  logic [TIM_W-1:0]            wdata_i,
  output logic [TIM_N-1:0][TIM_W-1:0] vals_o
);
  for (genvar i = 0; i < TIM_N; i++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      vals_o[i] <= TIM_W'(fgate_pkg::tim_rst(i));
      else if (we_i[i]) vals_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/fgate_top.sv
module fgate_top
  import fgate_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int TIM_N  = 4,
  parameter int TIM_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  logic                        locked, wr_pass, viol;
  logic [DW-1:0]               stat, mask;
  logic [TIM_N-1:0]            tim_we;
  logic [TIM_N-1:0][TIM_W-1:0] tim_vals;

  fgate_lock u_lock (
    .clk_i, .rst_ni, .wr_i,
    .lock_sel_i (addr_i == ADDR_W'(W_LOCK)),
    .wdata_i,
    .locked_o   (locked),
    .wr_pass_o  (wr_pass),
    .viol_o     (viol)
  );

  fgate_irq u_irq (
    .clk_i, .rst_ni,
    .wr_stat_i (wr_pass && addr_i == ADDR_W'(W_STAT)),
    .wr_en_i   (wr_pass && addr_i == ADDR_W'(W_MEN)),
    .wr_dis_i  (wr_pass && addr_i == ADDR_W'(W_MDIS)),
    .wdata_i,
    .evt_i,
    .viol_i    (viol),
    .stat_o    (stat),
    .mask_o    (mask),
    .irq_o
  );

  for (genvar i = 0; i < TIM_N; i++) begin : g_we
    assign tim_we[i] = wr_pass && addr_i == ADDR_W'(W_TIM0 + i);
  end

  fgate_tim #(.TIM_N(TIM_N), .TIM_W(TIM_W)) u_tim (
    .clk_i, .rst_ni,
    .we_i    (tim_we),
    .wdata_i (wdata_i[TIM_W-1:0]),
    .vals_o  (tim_vals)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == ADDR_W'(W_LOCK)) rdata_o = DW'(locked);
      if (addr_i == ADDR_W'(W_STAT)) rdata_o = stat;
      if (addr_i == ADDR_W'(W_MASK)) rdata_o = mask;
      for (int i = 0; i < TIM_N; i++)
        if (addr_i == ADDR_W'(W_TIM0 + i)) rdata_o = DW'(tim_vals[i]);
    end
  end

  // R3
  tim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && locked) |=> $stable(tim_vals));
endmodule

// File: tb/fgate_top_bench.sv
module fgate_top_bench;
  logic        clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0]  evt = '0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fgate_top u_fgate_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  localparam logic [5:0] A_LOCK = 0, A_STAT = 1, A_MASK = 2, A_MEN = 3,
                         A_MDIS = 4, A_TIM0 = 5;

  typedef struct packed {
    logic        is_rd;
    logic [5:0]  a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t [0:NV-1] VEC = '{
    '{1'b1, A_LOCK, 32'h1,          4'd1},  // R1
    '{1'b0, A_LOCK, 32'h0000_DF0E,  4'd2},
    '{1'b1, A_LOCK, 32'h1,          4'd2},  // R2 wrong key
    '{1'b0, A_TIM0, 32'h55,         4'd3},
    '{1'b1, A_TIM0, 32'h1B,         4'd3},  // R3 dropped
    '{1'b1, A_STAT, 32'h8000_0000,  4'd3},  // R3 flagged
    '{1'b0, A_LOCK, 32'h0001_DF0D,  4'd2},
    '{1'b1, A_LOCK, 32'h1,          4'd2},  // R2 upper bits differ
    '{1'b0, A_LOCK, 32'h0000_DF0D,  4'd2},
    '{1'b1, A_LOCK, 32'h0,          4'd2},  // R2 key opens
    '{1'b0, A_TIM0, 32'h1A5,        4'd10},
    '{1'b1, A_TIM0, 32'hA5,         4'd10}, // R10
    '{1'b0, A_STAT, 32'h8000_0000,  4'd6},
    '{1'b1, A_STAT, 32'h0,          4'd6},  // R6
    '{1'b0, A_MDIS, 32'h5,          4'd8},
    '{1'b1, A_MASK, 32'h8000_001A,  4'd8},  // R8 clear
    '{1'b1, A_MDIS, 32'h0,          4'd8},
    '{1'b0, A_MEN,  32'hFFFF_FF01,  4'd8},
    '{1'b1, A_MASK, 32'h8000_001B,  4'd8},  // R8 set
    '{1'b0, A_MASK, 32'h0,          4'd8},
    '{1'b1, A_MASK, 32'h8000_001B,  4'd8},  // R8 read-only
    '{1'b1, A_MEN,  32'h0,          4'd8},
    '{1'b0, A_LOCK, 32'h1234_5678,  4'd4},
    '{1'b1, A_LOCK, 32'h1,          4'd4},  // R4 relock
    '{1'b0, A_MEN,  32'h4,          4'd3},
    '{1'b1, A_MASK, 32'h8000_001B,  4'd3},  // R3
    '{1'b0, A_LOCK, 32'h0000_DF0D,  4'd4},
    '{1'b1, A_LOCK, 32'h0,          4'd4}   // R4
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input int req);
    addr = a; rd = 1; #1;
    check(rdata, exp, req);
    rd = 0;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk(A_MASK, 32'h8000_001F, 1);
    rd_chk(A_STAT, 32'h0, 1);
    check(32'(irq), 32'h0, 1);
    for (int i = 0; i < 4; i++)
      rd_chk(A_TIM0 + 6'(i), 32'(fgate_pkg::tim_rst(i)), 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) rd_chk(VEC[i].a, VEC[i].d, int'(VEC[i].req));
      else              wr_word(VEC[i].a, VEC[i].d);
    end

    // state: open, mask 8000001B, status 80000000
    check(32'(irq), 32'h1, 9);                // R9
    wr_word(A_STAT, 32'h8000_0000);
    check(32'(irq), 32'h0, 9);                // R9 cleared
    pulse(5'b00010);
    rd_chk(A_STAT, 32'h2, 5);                 // R5
    check(32'(irq), 32'h1, 9);
    pulse(5'b00100);
    wr_word(A_STAT, 32'h2);
    rd_chk(A_STAT, 32'h4, 6);                 // R6 only bit 1 cleared
    check(32'(irq), 32'h0, 9);                // R9 bit 2 masked
    wr_word(A_MEN, 32'h4);
    check(32'(irq), 32'h1, 9);                // R9 unmask
    // R7 event and clear collide on bit 3
    @(negedge clk); addr = A_STAT; wdata = 32'h8; wr = 1; evt = 5'b01000;
    @(negedge clk); wr = 0; evt = 0;
    rd_chk(A_STAT, 32'hC, 7);
    wr_word(A_STAT, 32'h0);
    rd_chk(A_STAT, 32'hC, 6);                 // R6 zero data
    pulse(5'b11111);
    rd_chk(A_STAT, 32'h1F, 5);                // R5 reserved zero
    wr_word(A_TIM0 + 6'd3, 32'hFFFF_FF00);
    check(32'(irq), 32'h1, 10);               // R10 no irq effect
    rd_chk(A_TIM0 + 6'd3, 32'h0, 10);
    wr_word(A_STAT, 32'hFFFF_FFFF);
    rd_chk(A_STAT, 32'h0, 6);
    check(32'(irq), 32'h0, 9);
    done = 1;
    finish_run();
  end
endmodule